// File: doc/BRIEF.md
# Serial Presence-Detect EEPROM Responder (Bit-Banged Two-Wire)

This block is a synthesizable, read-only model of a small two-wire serial EEPROM of the kind that holds serial presence detect data for a memory module. It has no real pins. A host drives the clock and data lines by writing a memory-mapped output register, and it reads the resulting data line back from an input register. Each write to the output register is one new sample of both lines. The block decodes START and STOP conditions from consecutive samples, shifts in a device/command byte and a word address, and acknowledges each byte. It then returns bytes from a fixed 256-byte presence-detect array.

The data line is a wired-AND of the host's level and the responder's drive. A pulled-low acknowledge therefore reads back as 0. A read usually runs in two parts. The host writes the word address with a write-direction command. It then issues a repeated START, sends a read-direction command and clocks data out. It acknowledges each byte it wants to continue with and ends the read with a not-acknowledge or a STOP.

Top module: `spd_eeprom_bitbang`

## Requirements
- R1: After the synchronous active-low reset, the responder is idle, does not drive the data line, and input register bit 0 reads 1.
- R2: A START is a pair of consecutive samples with SCL high in both and SDA going 1 to 0. A START restarts command-byte reception, even in the middle of a byte. A STOP is SDA going 0 to 1 with SCL high in both samples. A STOP ends any transfer and releases SDA.
- R3: While idle, the responder ignores all clocking until a START is seen. Clocked bytes get no acknowledge.
- R4: A data bit is taken on a sample where SCL goes 0 to 1, most significant bit first. It is taken only if SDA equals the previous sample. A sample that changes SDA together with the SCL rise counts as no bit.
- R5: Any 8-bit device/command byte is acknowledged. The responder pulls SDA low from the next SCL falling sample until the one after the ninth rise. Command bit 0 selects the direction: 1 is read and 0 is write.
- R6: After a write-direction command, the next byte is the word address. It is acknowledged in the same way. The responder then returns to idle, and further clocking is ignored until a START.
- R7: After a read-direction command, the responder sends the byte at the current address, most significant bit first. It changes SDA only on SCL falling samples and holds it while SCL is high.
- R8: After a sent byte, SDA held low by the host on the ninth clock advances the address by one and sends the next byte. The address wraps at the configured capacity.
- R9: SDA high on the ninth clock after a sent byte ends the read. SDA stays released for later clocks.
- R10: A STOP in the middle of a read byte releases SDA at once.
- R11: The `MEM_BYTES` parameter selects a capacity of 128 or 256 bytes. At 128, address bit 7 is ignored, so addresses 0x80 and above alias to 0x00 and up, and sequential reads wrap from 0x7F to 0x00.
- R12: The array contents are as follows. Bytes 0 to 7 are 80 08 04 0C 09 02 40 00 (hex). Byte i for 8 ≤ i ≤ 62 holds i. Byte 63 holds the low 8 bits of the sum of bytes 0 to 62. Byte i for i ≥ 64 holds i XOR 0xFF.
- R13: In the output register, bit 1 is SCL and bit 0 is SDA, and each write is one line sample. In the input register, bit 0 is the AND of the host's SDA and the responder's drive, and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Write strobe for the line output register; each strobe is one line sample |
| host_wr_data | input | REG_W | Output register data: bit 1 SCL, bit 0 SDA |
| host_rd_data | output | REG_W | Input register: bit 0 is the wired-AND SDA level, other bits 0 |

## Verification
The hardest state to reach from the ports is a glitch sample, where SDA changes on the same write that raises SCL, placed inside a byte. If such a bit were miscounted, every later bit would be misaligned. The stimulus inserts one glitch clock before every bit of a command byte. It then confirms that the acknowledge still lands on the ninth clean clock and that the addressed byte reads back intact. The other hard cases are a START in the middle of an address byte and a STOP in the middle of a read byte. Both are reached by truncating a byte after a few clocks and then checking that the line is released or that a fresh transfer works.

// File: rtl/spd_pkg.sv
// Shared types and array contents for the presence-detect responder.
// Assumes an 8-bit word address; the array always holds 256 entries.
package spd_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_DEV_ACK,
        PH_ADDR,
        PH_ADDR_ACK,
        PH_TX,
        PH_TX_ACK
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic bit_ok;
        logic bit_val;
    } line_evt_t;

    // Raw array byte excluding the checksum slot.
    function automatic logic [7:0] spd_raw(input int unsigned idx);
        case (idx)
            0: return 8'h80;
            1: return 8'h08;
            2: return 8'h04;
            3: return 8'h0C;
            4: return 8'h09;
            5: return 8'h02;
            6: return 8'h40;
            7: return 8'h00;
            default: begin
                if (idx < 63) return 8'(idx);
                else if (idx == 63) return 8'h00;
                else return 8'(idx) ^ 8'hFF;
            end
        endcase
    endfunction

    // Modulo-256 sum over the first 63 bytes.
    function automatic logic [7:0] spd_checksum();
        logic [7:0] acc;
        acc = 8'h00;
        for (int i = 0; i < 63; i++) acc = acc + spd_raw(i);
        return acc;
    endfunction

endpackage

// File: rtl/i2c_line_tap.sv
// Holds the last host-written SCL/SDA sample and classifies each new write
// as START, STOP, SCL rise (with a stability flag) or SCL fall.
// Assumes one sample per write strobe; events are valid only in that cycle.
module i2c_line_tap (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               scl_q,
    output logic               sda_q,
    output spd_pkg::line_evt_t evt
);

    // Compare the incoming sample with the stored one.
    always_comb begin
        evt = '0;
        if (wr_en) begin
            if (scl_q && scl_in && (sda_q != sda_in)) begin
                evt.start = !sda_in;
                evt.stop  = sda_in;
            end else if (!scl_q && scl_in) begin
                evt.rise    = 1'b1;
                evt.bit_ok  = (sda_q == sda_in);
                evt.bit_val = sda_in;
            end else if (scl_q && !scl_in) begin
                evt.fall = 1'b1;
            end
        end
    end

    // Store the sample; bus-idle levels after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else if (wr_en) begin
            scl_q <= scl_in;
            sda_q <= sda_in;
        end
    end

endmodule

// File: rtl/spd_rom.sv
// Fixed 256-byte presence-detect array with the checksum slot computed
// at elaboration. Purely combinational read.
module spd_rom #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [7:0]        data
);

    localparam int          CKSUM_IDX = 63;
    localparam logic [7:0]  CKSUM     = spd_pkg::spd_checksum();

    // Select the checksum slot or the computed content.
    always_comb begin
        if (int'(addr) == CKSUM_IDX) data = CKSUM;
        else                         data = spd_pkg::spd_raw(int'(addr));
    end

endmodule

// File: rtl/i2c_spd_fsm.sv
// Bus-side phase machine: receives the command and address bytes on clean
// SCL rises, acknowledges, and shifts out array bytes on SCL falls.
// Assumes MEM_BYTES is 128 or 256; all drive changes happen on SCL falls.
module i2c_spd_fsm #(
    parameter int MEM_BYTES = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  spd_pkg::line_evt_t evt,
    input  logic [7:0]         rom_data,
    output logic [7:0]         rom_addr,
    output logic               sda_drv
);
    import spd_pkg::*;

    localparam int         BYTE_BITS = 8;
    localparam logic [2:0] LAST_BIT  = 3'(BYTE_BITS - 1);

    phase_e     phase;
    logic [2:0] bit_cnt;
    logic [7:0] shreg;
    logic       rw_q;
    logic [7:0] addr_q;
    logic [7:0] data_sh;
    logic [7:0] keep_mask;
    logic [7:0] addr_new;
    logic [7:0] addr_inc;

    // Capacity variant: full 8-bit address or bit 7 dropped.
    generate
        if (MEM_BYTES >= 256) begin : g_full
            assign keep_mask = 8'hFF;
        end else begin : g_half
            assign keep_mask = 8'(MEM_BYTES - 1);
        end
    endgenerate

    assign addr_new = {shreg[6:0], evt.bit_val} & keep_mask;
    assign addr_inc = (addr_q + 8'd1) & keep_mask;

    // Array read address for the byte about to be latched.
    always_comb begin
        rom_addr = addr_q;
        if (phase == PH_ADDR)        rom_addr = addr_new;
        else if (phase == PH_TX_ACK) rom_addr = addr_inc;
    end

    // Phase, counters, shift registers and data-line drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            rw_q    <= 1'b0;
            addr_q  <= '0;
            data_sh <= '0;
            sda_drv <= 1'b1;
        end else if (evt.start) begin
            phase   <= PH_DEV;
            bit_cnt <= '0;
            shreg   <= '0;
            sda_drv <= 1'b1;
        end else if (evt.stop) begin
            phase   <= PH_IDLE;
            bit_cnt <= '0;
            sda_drv <= 1'b1;
        end else if (evt.rise && evt.bit_ok) begin
            case (phase)
                PH_DEV: begin
                    shreg   <= {shreg[6:0], evt.bit_val};
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == LAST_BIT) begin
                        rw_q    <= evt.bit_val;
                        bit_cnt <= '0;
                        phase   <= PH_DEV_ACK;
                    end
                end
                PH_DEV_ACK: begin
                    bit_cnt <= '0;
                    shreg   <= '0;
                    if (rw_q) begin
                        data_sh <= rom_data;
                        phase   <= PH_TX;
                    end else begin
                        phase   <= PH_ADDR;
                    end
                end
                PH_ADDR: begin
                    shreg   <= {shreg[6:0], evt.bit_val};
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == LAST_BIT) begin
                        addr_q  <= addr_new;
                        data_sh <= rom_data;
                        bit_cnt <= '0;
                        phase   <= PH_ADDR_ACK;
                    end
                end
                PH_ADDR_ACK: phase <= PH_IDLE;
                PH_TX: begin
                    data_sh <= {data_sh[6:0], 1'b0};
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == LAST_BIT) begin
                        bit_cnt <= '0;
                        phase   <= PH_TX_ACK;
                    end
                end
                PH_TX_ACK: begin
                    if (!evt.bit_val) begin
                        addr_q  <= addr_inc;
                        data_sh <= rom_data;
                        phase   <= PH_TX;
                    end else begin
                        phase   <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end else if (evt.fall) begin
            case (phase)
                PH_DEV_ACK, PH_ADDR_ACK: sda_drv <= 1'b0;
                PH_TX:                   sda_drv <= data_sh[7];
                default:                 sda_drv <= 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/spd_eeprom_bitbang.sv
// Top: register wrapper around the line tap, phase machine and array.
// Output register bit 1 = SCL, bit 0 = SDA; every write is a line sample.
// Input register bit 0 = wired-AND of host SDA and responder drive.
module spd_eeprom_bitbang #(
    parameter int REG_W     = 32,
    parameter int MEM_BYTES = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr_en,
    input  logic [REG_W-1:0] host_wr_data,
    output logic [REG_W-1:0] host_rd_data
);

    localparam int SCL_POS = 1;
    localparam int SDA_POS = 0;

    logic               scl_q;
    logic               sda_q;
    logic               sda_drv;
    logic [7:0]         rom_addr;
    logic [7:0]         rom_data;
    spd_pkg::line_evt_t line_evt;

    i2c_line_tap u_tap (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (host_wr_en),
        .scl_in (host_wr_data[SCL_POS]),
        .sda_in (host_wr_data[SDA_POS]),
        .scl_q  (scl_q),
        .sda_q  (sda_q),
        .evt    (line_evt)
    );

    i2c_spd_fsm #(.MEM_BYTES(MEM_BYTES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (line_evt),
        .rom_data (rom_data),
        .rom_addr (rom_addr),
        .sda_drv  (sda_drv)
    );

    spd_rom #(.ADDR_W(8)) u_rom (
        .addr (rom_addr),
        .data (rom_data)
    );

    // Input register: wired-AND data level in bit 0.
    always_comb begin
        host_rd_data          = '0;
        host_rd_data[SDA_POS] = sda_q & sda_drv;
    end

endmodule

// File: rtl/spd_eeprom_bitbang_chk.sv
// Property checker for the responder; attached to the top by bind.
module spd_eeprom_bitbang_chk #(
    parameter int REG_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_wr_en,
    input logic               wr_scl,
    input logic [REG_W-1:0]   host_rd_data,
    input logic               scl_q,
    input logic               sda_drv,
    input spd_pkg::line_evt_t line_evt
);

    a_r1_reset_release: assert property (@(posedge clk)
        !rst_n |=> host_rd_data[0]);

    a_r13_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_data[REG_W-1:1] == '0);

    a_r2_start_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        (line_evt.start || line_evt.stop) |=> sda_drv);

    a_r7_drive_on_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drv) |-> $past(host_wr_en));

    a_r7_hold_while_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && scl_q && wr_scl && !line_evt.start && !line_evt.stop)
        |=> $stable(sda_drv));

endmodule

bind spd_eeprom_bitbang spd_eeprom_bitbang_chk #(.REG_W(REG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr_en   (host_wr_en),
    .wr_scl       (host_wr_data[1]),
    .host_rd_data (host_rd_data),
    .scl_q        (scl_q),
    .sda_drv      (sda_drv),
    .line_evt     (line_evt)
);

// File: tb/spd_eeprom_bitbang_tb_top.sv
// Directed bench: one task per scenario; 256-byte and 128-byte instances
// receive identical line samples.
module spd_eeprom_bitbang_tb_top;

    localparam int REG_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [REG_W-1:0] wr_data = '0;
    logic [REG_W-1:0] rd_big;
    logic [REG_W-1:0] rd_small;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    spd_eeprom_bitbang #(.REG_W(REG_W), .MEM_BYTES(256)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr_en(wr_en),
        .host_wr_data(wr_data), .host_rd_data(rd_big));

    spd_eeprom_bitbang #(.REG_W(REG_W), .MEM_BYTES(128)) dut_small_i (
        .clk(clk), .rst_n(rst_n), .host_wr_en(wr_en),
        .host_wr_data(wr_data), .host_rd_data(rd_small));

    // Expected array contents (R12), written from the requirement.
    function automatic logic [7:0] exp_byte(input int a);
        logic [7:0] hdr [8] = '{8'h80, 8'h08, 8'h04, 8'h0C, 8'h09, 8'h02, 8'h40, 8'h00};
        logic [7:0] s;
        if (a < 8) return hdr[a];
        if (a < 63) return 8'(a);
        if (a == 63) begin
            s = 8'h00;
            for (int i = 0; i < 8; i++) s = s + hdr[i];
            for (int i = 8; i < 63; i++) s = s + 8'(i);
            return s;
        end
        return 8'(a) ^ 8'hFF;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input logic scl, input logic sda);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = {30'b0, scl, sda};
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic xfer_bit(input logic b, output logic gb, output logic gs);
        put(1'b0, b);
        put(1'b1, b);
        gb = rd_big[0];
        gs = rd_small[0];
        put(1'b0, b);
    endtask

    task automatic glitch_bit(input logic b);
        put(1'b0, !b);
        put(1'b1, b);
        put(1'b0, b);
    endtask

    task automatic do_start();
        put(1'b0, 1'b1);
        put(1'b1, 1'b1);
        put(1'b1, 1'b0);
        put(1'b0, 1'b0);
    endtask

    task automatic do_stop();
        put(1'b0, 1'b0);
        put(1'b1, 1'b0);
        put(1'b1, 1'b1);
    endtask

    task automatic send_byte(input logic [7:0] v, input logic glitchy,
                             output logic ab, output logic as_);
        logic gb, gs;
        for (int i = 7; i >= 0; i--) begin
            if (glitchy) glitch_bit(v[i]);
            xfer_bit(v[i], gb, gs);
        end
        xfer_bit(1'b1, gb, gs);
        ab  = !gb;
        as_ = !gs;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] vb, output logic [7:0] vs);
        logic gb, gs;
        for (int i = 7; i >= 0; i--) begin
            xfer_bit(1'b1, gb, gs);
            vb[i] = gb;
            vs[i] = gs;
        end
        xfer_bit(!mack, gb, gs);
    endtask

    // Address phase plus repeated START and read command; acks checked (R5, R6).
    task automatic addr_setup(input logic [7:0] a, input logic glitchy);
        logic ab, as_;
        do_start();
        send_byte(8'hA0, glitchy, ab, as_);
        check("R5 write-cmd ack", {ab, as_}, 2'b11);
        send_byte(a, 1'b0, ab, as_);
        check("R6 address ack", {ab, as_}, 2'b11);
        do_start();
        send_byte(8'hA1, 1'b0, ab, as_);
        check("R5 read-cmd ack", {ab, as_}, 2'b11);
    endtask

    task automatic t_reset();
        check("R1 reset line level big", rd_big, 32'h1);
        check("R1 reset line level small", rd_small, 32'h1);
    endtask

    task automatic t_wired_and();
        put(1'b0, 1'b0);
        check("R13 host low reads low", rd_big, 32'h0);
        put(1'b0, 1'b1);
        check("R13 host high reads high", rd_big, 32'h1);
    endtask

    task automatic t_idle_ignore();
        logic ab, as_;
        send_byte(8'hA0, 1'b0, ab, as_);
        check("R3 no ack without START", {ab, as_}, 2'b00);
    endtask

    task automatic t_random_read();
        logic [7:0] vb, vs;
        addr_setup(8'h05, 1'b0);
        recv_byte(1'b0, vb, vs);
        check("R7 R12 byte at 0x05", vb, exp_byte(5));
        check("R7 small byte at 0x05", vs, exp_byte(5));
        do_stop();
    endtask

    task automatic t_seq_read();
        logic [7:0] vb, vs;
        addr_setup(8'h3E, 1'b0);
        for (int k = 0; k < 3; k++) begin
            recv_byte(k != 2, vb, vs);
            check("R8 R12 sequential byte", vb, exp_byte(8'h3E + k));
            check("R8 small sequential byte", vs, exp_byte(8'h3E + k));
        end
        do_stop();
    endtask

    task automatic t_wrap();
        logic [7:0] vb, vs;
        addr_setup(8'hFF, 1'b0);
        recv_byte(1'b1, vb, vs);
        check("R8 big byte at 0xFF", vb, exp_byte(255));
        check("R11 small aliases 0xFF to 0x7F", vs, exp_byte(127));
        recv_byte(1'b0, vb, vs);
        check("R8 big wraps to 0x00", vb, exp_byte(0));
        check("R11 small wraps to 0x00", vs, exp_byte(0));
        do_stop();
        addr_setup(8'h85, 1'b0);
        recv_byte(1'b0, vb, vs);
        check("R11 big byte at 0x85", vb, exp_byte(8'h85));
        check("R11 small byte at 0x05", vs, exp_byte(5));
        do_stop();
    endtask

    task automatic t_nack_ends();
        logic [7:0] vb, vs;
        addr_setup(8'h20, 1'b0);
        recv_byte(1'b0, vb, vs);
        check("R9 byte before nack", vb, exp_byte(8'h20));
        recv_byte(1'b0, vb, vs);
        check("R9 released after nack big", vb, 8'hFF);
        check("R9 released after nack small", vs, 8'hFF);
        do_stop();
    endtask

    task automatic t_stop_mid_read();
        logic gb, gs;
        logic [7:0] vb, vs;
        addr_setup(8'h40, 1'b0);
        for (int i = 0; i < 3; i++) xfer_bit(1'b1, gb, gs);
        do_stop();
        check("R10 released right after STOP", rd_big, 32'h1);
        recv_byte(1'b0, vb, vs);
        check("R10 R2 line stays released", {vb, vs}, 16'hFFFF);
    endtask

    task automatic t_addr_then_idle();
        logic ab, as_;
        logic [7:0] vb, vs;
        do_start();
        send_byte(8'hA0, 1'b0, ab, as_);
        send_byte(8'h11, 1'b0, ab, as_);
        check("R6 address acked", {ab, as_}, 2'b11);
        recv_byte(1'b0, vb, vs);
        check("R6 idle after address", {vb, vs}, 16'hFFFF);
        do_stop();
    endtask

    task automatic t_start_mid_byte();
        logic gb, gs;
        logic [7:0] vb, vs;
        logic ab, as_;
        do_start();
        send_byte(8'hA0, 1'b0, ab, as_);
        for (int i = 0; i < 3; i++) xfer_bit(1'b1, gb, gs);
        addr_setup(8'h22, 1'b0);
        recv_byte(1'b0, vb, vs);
        check("R2 restart mid address byte", vb, exp_byte(8'h22));
        do_stop();
    endtask

    task automatic t_glitch();
        logic [7:0] vb, vs;
        addr_setup(8'h10, 1'b1);
        recv_byte(1'b0, vb, vs);
        check("R4 glitch clocks ignored", vb, exp_byte(8'h10));
        do_stop();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wired_and();
        t_idle_ignore();
        t_random_read();
        t_seq_read();
        t_wrap();
        t_nack_ends();
        t_stop_mid_read();
        t_addr_then_idle();
        t_start_mid_byte();
        t_glitch();
        finish_run();
    end

endmodule